// File: doc/BRIEF.md
# Packed Single-Precision Compare and Select Unit

This unit takes a destination operand and a source operand, each 64 bits wide and holding two IEEE-754 single-precision values, and applies one of five lane-wise operations picked by an 8-bit operation code. Three of the operations are predicates: equal, greater-or-equal and greater-than, each tested as destination against source. A predicate fills a 32-bit lane with all ones when it holds and with all zeros when it does not. The other two operations are maximum and minimum. Each keeps the destination lane and takes the source lane only when the source strictly wins.

No floating-point arithmetic is used. Order is worked out from the sign bit and the magnitude bits of the raw patterns, so that +0 and -0 are equal. Any comparison with a NaN is unordered and counts as false. The result and a valid strobe come out of a register one clock after the request. A pipeline sequencer places one request per cycle by raising the request strobe.

Top module: `pfp_cmp_unit`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next clock edge, and `out_valid` is low after any cycle without a request. While reset is asserted, and after it is released until the first request, `out_valid` and `result_o` are 0.
- R2: Code 0xB0 (equal) sets a lane to 0xFFFFFFFF when destination equals source and to 0x00000000 otherwise. +0 (0x00000000) and -0 (0x80000000) count as equal.
- R3: Code 0x90 (greater-or-equal) and code 0xA0 (greater-than) produce lane masks for destination >= source and destination > source. Order follows sign, then magnitude, with negative values reversed.
- R4: Code 0xA4 (maximum) returns the source lane bits only when source > destination, and returns the destination lane bits otherwise, including on equality.
- R5: Code 0x94 (minimum) returns the source lane bits only when source < destination, and returns the destination lane bits otherwise, including on equality.
- R6: A lane value whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero is a NaN. Every predicate involving it is false, so masks are 0 and maximum/minimum return the destination lane.
- R7: Lane 0 is bits 31:0 and lane 1 is bits 63:32. Each lane's result depends only on that lane of the two operands.
- R8: `result_o` keeps its value during cycles without a request.
- R9: Any other operation code produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| op_sel | input | 8 | Operation code |
| dst_i | input | 64 | Destination operand, two single-precision lanes |
| src_i | input | 64 | Source operand, two single-precision lanes |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 64 | Registered lane result |

## Verification
The checker compares the primary reset input with the outputs. It therefore assumes that no request arrives while the internal reset synchronizer is still holding the unit in reset, which lasts two edges after `rst_n` rises. The bench keeps `in_valid` low for several cycles after release. The properties on maximum and minimum also assume that the operands seen at the previous edge are the ones that were registered, which holds because every request is a single-cycle strobe driven away from the clock edge. The directed stimulus covers signed zeros, infinities, equal values, NaN in either lane and unknown codes.

// File: rtl/pfp_cmp_pkg.sv
package pfp_cmp_pkg;
  localparam logic [7:0] OP_EQ  = 8'hB0;
  localparam logic [7:0] OP_GE  = 8'h90;
  localparam logic [7:0] OP_GT  = 8'hA0;
  localparam logic [7:0] OP_MAX = 8'hA4;
  localparam logic [7:0] OP_MIN = 8'h94;

  // relation of destination (a) to source (b); all clear when unordered
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } rel_t;
endpackage

// File: rtl/pfp_rst_sync.sv
module pfp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfp_lane_rel.sv
module pfp_lane_rel
  import pfp_cmp_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output rel_t         rel
);
  localparam int MAN_W = W - 1 - EXP_W;

  logic         a_nan, b_nan, both_zero, a_lt_raw, eq_raw;
  logic [W-2:0] mag_a, mag_b;

  assign mag_a     = a[W-2:0];
  assign mag_b     = b[W-2:0];
  assign a_nan     = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign b_nan     = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
  assign both_zero = (~|mag_a) && (~|mag_b);
  assign eq_raw    = both_zero || (a == b);

  always_comb begin
    if (both_zero)               a_lt_raw = 1'b0;
    else if (a[W-1] != b[W-1])   a_lt_raw = a[W-1];
    else if (!a[W-1])            a_lt_raw = (mag_a < mag_b);
    else                         a_lt_raw = (mag_a > mag_b);
  end

  always_comb begin
    if (a_nan || b_nan) begin
      rel = '0;
    end else begin
      rel.eq = eq_raw;
      rel.lt = a_lt_raw;
      rel.gt = !eq_raw && !a_lt_raw;
    end
  end
endmodule

// File: rtl/pfp_lane_pick.sv
module pfp_lane_pick
  import pfp_cmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  rel_t         rel,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_EQ:   res = {W{rel.eq}};
      OP_GE:   res = {W{rel.eq | rel.gt}};
      OP_GT:   res = {W{rel.gt}};
      OP_MAX:  res = rel.lt ? b : a;
      OP_MIN:  res = rel.gt ? b : a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/pfp_cmp_unit.sv
module pfp_cmp_unit
  import pfp_cmp_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2,
  parameter int EXP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              op_sel,
  input  logic [LANE_W*LANES-1:0] dst_i,
  input  logic [LANE_W*LANES-1:0] src_i,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result_o
);
  localparam int DW = LANE_W * LANES;

  logic          rst_n_int;
  logic [DW-1:0] lane_res;
  logic [DW-1:0] res_d, res_q;
  logic          vld_d, vld_q;

  pfp_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rel_t rel;
    pfp_lane_rel #(.W(LANE_W), .EXP_W(EXP_W)) rel_i (
      .a   (dst_i[g*LANE_W +: LANE_W]),
      .b   (src_i[g*LANE_W +: LANE_W]),
      .rel (rel)
    );
    pfp_lane_pick #(.W(LANE_W)) pick_i (
      .op  (op_sel),
      .a   (dst_i[g*LANE_W +: LANE_W]),
      .b   (src_i[g*LANE_W +: LANE_W]),
      .rel (rel),
      .res (lane_res[g*LANE_W +: LANE_W])
    );
  end

  // next state
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? lane_res : res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result_o  = res_q;
endmodule

// File: rtl/pfp_cmp_unit_chk.sv
module pfp_cmp_unit_chk
  import pfp_cmp_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [7:0]              op_sel,
  input logic [LANE_W*LANES-1:0] dst_i,
  input logic [LANE_W*LANES-1:0] src_i,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] result_o
);
  logic [LANE_W-1:0] r0, d0, s0;
  logic              d0_nan;
  assign r0     = result_o[LANE_W-1:0];
  assign d0     = dst_i[LANE_W-1:0];
  assign s0     = src_i[LANE_W-1:0];
  assign d0_nan = (&d0[LANE_W-2:LANE_W-9]) && (|d0[LANE_W-10:0]);

  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result_o));
  a_r2_eq_is_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_EQ) |=> (r0 == '0 || r0 == '1));
  a_r3_ge_is_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_GE) |=> (r0 == '0 || r0 == '1));
  a_r4_max_picks_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_MAX) |=> (r0 == $past(d0) || r0 == $past(s0)));
  a_r5_min_picks_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_MIN) |=> (r0 == $past(d0) || r0 == $past(s0)));
  a_r6_nan_eq_false: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_EQ && d0_nan) |=> (r0 == '0));
  a_r9_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel != OP_EQ && op_sel != OP_GE && op_sel != OP_GT &&
     op_sel != OP_MAX && op_sel != OP_MIN) |=> (result_o == '0));
endmodule

bind pfp_cmp_unit pfp_cmp_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .dst_i(dst_i), .src_i(src_i), .out_valid(out_valid), .result_o(result_o)
);

// File: tb/pfp_cmp_unit_tb_top.sv
module pfp_cmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN = 32'h7FC00000, PINF = 32'h7F800000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  op_sel;
  logic [63:0] dst_i, src_i;
  logic        out_valid;
  logic [63:0] result_o;
  int          total = 0;
  int          bad = 0;
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfp_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .dst_i(dst_i), .src_i(src_i), .out_valid(out_valid), .result_o(result_o)
  );

  // independent reference: map patterns to an unsigned ordering key
  function automatic logic [31:0] key_of(input logic [31:0] x);
    if (x[30:0] == 31'd0) return 32'h80000000;
    return x[31] ? ~x : (x | 32'h80000000);
  endfunction

  function automatic logic is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic [31:0] ref_lane(input logic [7:0] op,
                                           input logic [31:0] d, s);
    logic un, eq, gt, lt;
    un = is_nan(d) || is_nan(s);
    eq = !un && key_of(d) == key_of(s);
    gt = !un && key_of(d) >  key_of(s);
    lt = !un && key_of(d) <  key_of(s);
    case (op)
      8'hB0:   return eq ? 32'hFFFFFFFF : 32'h0;
      8'h90:   return (eq || gt) ? 32'hFFFFFFFF : 32'h0;
      8'hA0:   return gt ? 32'hFFFFFFFF : 32'h0;
      8'hA4:   return lt ? s : d;
      8'h94:   return gt ? s : d;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request, checked on the following negedge
  task automatic run_op(input logic [7:0] op, input logic [63:0] d, s, input string tag);
    logic [63:0] exp;
    exp = {ref_lane(op, d[63:32], s[63:32]), ref_lane(op, d[31:0], s[31:0])};
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; dst_i = d; src_i = s;
    @(negedge clk);
    check({63'd0, out_valid}, 64'd1, {tag, " R1 strobe"});
    check(result_o, exp, tag);
    in_valid = 1'b0; op_sel = 8'h00; dst_i = '1; src_i = '1;
  endtask

  task automatic t_reset;
    check({63'd0, out_valid}, 64'd0, "R1 reset out_valid");
    check(result_o, 64'd0, "R1 reset result");
  endtask

  task automatic t_equal;
    run_op(8'hB0, {P1, PZ}, {P1, NZ}, "R2 eq equal/signed zero");
    check(result_o, 64'hFFFFFFFF_FFFFFFFF, "R2 eq both lanes set");
    run_op(8'hB0, {P1, N1}, {P2, P1}, "R2 eq differ");
    run_op(8'hB0, {PINF, N2}, {PINF, N2}, "R2 eq inf");
  endtask

  task automatic t_order;
    run_op(8'h90, {P1, N1}, {P1, N2}, "R3 ge eq/neg");
    run_op(8'hA0, {P1, N1}, {P1, N2}, "R3 gt eq/neg");
    run_op(8'hA0, {N2, NZ}, {N1, PZ}, "R3 gt neg/zero");
    run_op(8'h90, {P2, N2}, {PINF, P1}, "R3 ge lower");
    check(result_o, 64'd0, "R3 ge both below");
  endtask

  task automatic t_max;
    run_op(8'hA4, {P1, N1}, {P2, N2}, "R4 max");
    check(result_o, {P2, N1}, "R4 max literal");
    run_op(8'hA4, {NZ, P1}, {PZ, P1}, "R4 max equal keeps dst");
    check(result_o[63:32], NZ, "R4 max -0 vs +0 keeps dst");
  endtask

  task automatic t_min;
    run_op(8'h94, {P1, N1}, {P2, N2}, "R5 min");
    check(result_o, {P1, N2}, "R5 min literal");
    run_op(8'h94, {PZ, N1}, {NZ, N1}, "R5 min equal keeps dst");
  endtask

  task automatic t_nan;
    run_op(8'hB0, {QN, QN}, {QN, P1}, "R6 eq nan");
    run_op(8'h90, {P1, QN}, {QN, P1}, "R6 ge nan");
    run_op(8'hA4, {P1, QN}, {QN, P1}, "R6 max nan keeps dst");
    check(result_o, {P1, QN}, "R6 max nan literal");
    run_op(8'h94, {QN, N1}, {N2, QN}, "R6 min nan keeps dst");
  endtask

  task automatic t_lanes;
    run_op(8'hA0, {P2, P1}, {P1, P2}, "R7 lanes independent");
    check(result_o, {32'hFFFFFFFF, 32'h0}, "R7 lane 1 set lane 0 clear");
  endtask

  task automatic t_hold;
    logic [63:0] prev;
    run_op(8'hA4, {P2, N1}, {P1, N2}, "R8 setup");
    prev = result_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check({63'd0, out_valid}, 64'd0, "R1 idle no strobe");
      check(result_o, prev, "R8 hold while idle");
    end
  endtask

  task automatic t_bad_op;
    run_op(8'h00, {P1, P1}, {P1, P1}, "R9 code 00");
    run_op(8'hB4, {P1, N1}, {P2, N2}, "R9 code B4");
    check(result_o, 64'd0, "R9 zero result");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 8'h00; dst_i = '0; src_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_equal();
    t_order();
    t_max();
    t_min();
    t_nan();
    t_lanes();
    t_hold();
    t_bad_op();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule